// File: doc/BRIEF.md
# Element Array to Word Stream Serializer

This block takes an array of fixed-width elements and sends it out as one AXI4-Stream packet of fixed-width words. Before the elements arrive, the caller pulses a start input together with the element count. Elements then come in one at a time over a valid/ready handshake. The block cuts each element into a fixed number of words and sends those words with the least significant word first. Words from consecutive elements follow each other with no gap words between them. TLAST is raised only on the last word of the last element.

An element may be narrower than one word, for example an 8- or 16-bit scalar in a 32-bit word. It still takes one full word, and the unused upper bits are zero. If a wide element is not a whole multiple of the word width, its top word is padded with zeros in the same way. A count of zero is refused with an error pulse. A start pulse that arrives while a packet is running has no effect.

Top module: `arr_burst_ser`

## Requirements
- R1: Each element produces exactly WPE = ceil(ELEM_W / WORD_W) accepted output beats. A packet of N elements therefore has N*WPE beats. WORD_W defaults to 32.
- R2: All beats of one call form a single packet. m_tlast is 1 only on the final beat of the last element, and busy_o is 0 in the cycle after that beat is accepted.
- R3: Beat k of element e carries bits [k*WORD_W +: WORD_W] of that element, least significant word first (k = 0..WPE-1). The first word of element e+1 directly follows the last word of element e, with no padding words.
- R4: Bits of the element's last word that lie above ELEM_W are driven to 0. This covers a narrow scalar in a full word and the top word of a wide element.
- R5: A call with count 1 produces one packet of exactly WPE beats, with m_tlast on beat WPE-1.
- R6: While m_tvalid is 1 and m_tready is 0, m_tvalid stays 1 and m_tdata and m_tlast keep their values on the next cycle.
- R7: Once an element is accepted, elem_ready_o stays 0 until that element's last word has been accepted. While busy_o is 1 and no beat is pending, elem_ready_o is 1.
- R8: A start with count 0 makes err_o 1 for exactly the one cycle after the start edge. No beat is sent and busy_o stays 0.
- R9: busy_o rises in the cycle after a start with a nonzero count. A start while busy_o is 1 changes neither the packet length nor the completion point.
- R10: After reset, busy_o, m_tvalid, elem_ready_o and err_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse; samples count_i |
| count_i | input | CNT_W | Number of elements in the array |
| elem_valid_i | input | 1 | Element data is valid |
| elem_ready_o | output | 1 | Block can accept an element |
| elem_data_i | input | ELEM_W | Element value |
| m_tvalid | output | 1 | Stream beat valid |
| m_tready | input | 1 | Stream sink ready |
| m_tdata | output | WORD_W | Stream word |
| m_tlast | output | 1 | Final beat of the packet |
| busy_o | output | 1 | Packet in progress |
| err_o | output | 1 | One-cycle pulse on a zero-count start |

## Verification
- Start and busy: busy_o and elem_ready_o respond one edge after the start edge, and err_o pulses in that same cycle after a zero-count start.
- First beat: an accepted element shows up as a valid beat one edge after its handshake edge. Each later word of the element follows one edge after the previous word is accepted.
- End of packet: busy_o drops one edge after the TLAST beat is accepted.
- Sampling: the bench drives inputs just after the rising edge and samples every output at the falling edge. A handshake seen at a falling edge is therefore the one taken at the next rising edge. The bench records beats and checks for hold and ready violations continuously, then compares them against the word slicing that R3 and R4 define.

// File: rtl/arr_ser_pkg.sv
package arr_ser_pkg;

    typedef enum logic [0:0] {
        CTL_IDLE = 1'b0,
        CTL_RUN  = 1'b1
    } ctl_state_e;

    function automatic int words_per_elem(input int elem_w, input int word_w);
        return (elem_w + word_w - 1) / word_w;
    endfunction

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/arr_ser_ctrl.sv
module arr_ser_ctrl
    import arr_ser_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             elem_done_i,
    output logic             busy_o,
    output logic             last_elem_o,
    output logic             err_o
);

    ctl_state_e       state_q;
    logic [CNT_W-1:0] remain_q;
    logic             err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= CTL_IDLE;
            remain_q <= '0;
            err_q    <= 1'b0;
        end else begin
            err_q <= 1'b0;
            case (state_q)
                CTL_IDLE: begin
                    if (start_i) begin
                        if (count_i == '0) begin
                            err_q <= 1'b1;
                        end else begin
                            remain_q <= count_i;
                            state_q  <= CTL_RUN;
                        end
                    end
                end
                CTL_RUN: begin
                    if (elem_done_i) begin
                        remain_q <= remain_q - 1'b1;
                        if (remain_q == {{(CNT_W-1){1'b0}}, 1'b1}) begin
                            state_q <= CTL_IDLE;
                        end
                    end
                end
                default: state_q <= CTL_IDLE;
            endcase
        end
    end

    assign busy_o      = (state_q == CTL_RUN);
    assign last_elem_o = (remain_q == {{(CNT_W-1){1'b0}}, 1'b1});
    assign err_o       = err_q;

    AST_ERR_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        err_o |-> !busy_o); // R8

    AST_START_ENTERS_RUN: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && start_i && count_i != '0) |=> busy_o); // R9

    AST_RUN_IGNORES_START: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !elem_done_i) |=> (busy_o && $stable(remain_q))); // R9

endmodule

// File: rtl/arr_ser_slicer.sv
module arr_ser_slicer
    import arr_ser_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int ELEM_W = 80
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [ELEM_W-1:0] elem_i,
    input  logic              last_elem_i,
    output logic              hold_o,
    output logic [WORD_W-1:0] word_o,
    output logic              tlast_o,
    input  logic              take_i,
    output logic              elem_done_o
);

    localparam int WPE   = words_per_elem(ELEM_W, WORD_W);
    localparam int SR_W  = WPE * WORD_W;
    localparam int IDX_W = idx_width(WPE);
    localparam int PAD_W = SR_W - ELEM_W;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WPE - 1);

    logic [SR_W-1:0]  sr_q;
    logic [IDX_W-1:0] idx_q;
    logic             hold_q;
    logic             lastel_q;
    logic [SR_W-1:0]  elem_ext;
    logic             final_word;

    generate
        if (PAD_W > 0) begin : g_pad
            assign elem_ext = {{PAD_W{1'b0}}, elem_i};
        end else begin : g_nopad
            assign elem_ext = elem_i;
        end
    endgenerate

    assign final_word = (idx_q == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q     <= '0;
            idx_q    <= '0;
            hold_q   <= 1'b0;
            lastel_q <= 1'b0;
        end else if (load_i && !hold_q) begin
            sr_q     <= elem_ext;
            idx_q    <= '0;
            hold_q   <= 1'b1;
            lastel_q <= last_elem_i;
        end else if (hold_q && take_i) begin
            if (final_word) begin
                hold_q <= 1'b0;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
            if (WPE > 1) begin
                sr_q <= sr_q >> WORD_W;
            end
        end
    end

    assign hold_o      = hold_q;
    assign word_o      = sr_q[WORD_W-1:0];
    assign tlast_o     = hold_q && lastel_q && final_word;
    assign elem_done_o = hold_q && take_i && final_word;

    AST_LOAD_MAKES_BEAT: assert property (@(posedge clk) disable iff (rst)
        (load_i && !hold_o) |=> hold_o); // R1

    AST_WORD_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (hold_o && take_i && !elem_done_o) |=> hold_o); // R1

    generate
        if (PAD_W > 0) begin : g_pad_chk
            localparam int TOP_USED = WORD_W - PAD_W;
            AST_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
                (hold_o && final_word) |-> (word_o[WORD_W-1:TOP_USED] == '0)); // R4
        end
    endgenerate

endmodule

// File: rtl/arr_burst_ser.sv
module arr_burst_ser
    import arr_ser_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int ELEM_W = 80,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              elem_valid_i,
    output logic              elem_ready_o,
    input  logic [ELEM_W-1:0] elem_data_i,
    output logic              m_tvalid,
    input  logic              m_tready,
    output logic [WORD_W-1:0] m_tdata,
    output logic              m_tlast,
    output logic              busy_o,
    output logic              err_o
);

    logic busy;
    logic last_elem;
    logic elem_done;
    logic hold;
    logic load;

    arr_ser_ctrl #(
        .CNT_W (CNT_W)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .count_i     (count_i),
        .elem_done_i (elem_done),
        .busy_o      (busy),
        .last_elem_o (last_elem),
        .err_o       (err_o)
    );

    assign elem_ready_o = busy && !hold;
    assign load         = elem_valid_i && elem_ready_o;

    arr_ser_slicer #(
        .WORD_W (WORD_W),
        .ELEM_W (ELEM_W)
    ) u_slice (
        .clk         (clk),
        .rst         (rst),
        .load_i      (load),
        .elem_i      (elem_data_i),
        .last_elem_i (last_elem),
        .hold_o      (hold),
        .word_o      (m_tdata),
        .tlast_o     (m_tlast),
        .take_i      (m_tready),
        .elem_done_o (elem_done)
    );

    assign m_tvalid = hold;
    assign busy_o   = busy;

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast))); // R6

    AST_LAST_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && m_tready && m_tlast) |=> !busy_o); // R2

    AST_BEAT_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        m_tvalid |-> busy_o); // R2

    AST_NO_READY_WITH_BEAT: assert property (@(posedge clk) disable iff (rst)
        (elem_valid_i && elem_ready_o) |=> !elem_ready_o); // R7

endmodule

// File: tb/test_arr_burst_ser.sv
module test_arr_burst_ser;

    localparam int WORD_W = 32;
    localparam int ELEM_W = 80;
    localparam int CNT_W  = 16;
    localparam int WPE    = (ELEM_W + WORD_W - 1) / WORD_W;
    localparam int SR_W   = WPE * WORD_W;
    localparam int MAXB   = 256;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start_i = 1'b0;
    logic [CNT_W-1:0]  count_i = '0;
    logic              elem_valid_i = 1'b0;
    logic              elem_ready_o;
    logic [ELEM_W-1:0] elem_data_i = '0;
    logic              m_tvalid;
    logic              m_tready;
    logic [WORD_W-1:0] m_tdata;
    logic              m_tlast;
    logic              busy_o;
    logic              err_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    bit bp_en = 0;
    int cyc = 0;

    logic [WORD_W-1:0] bt_data [MAXB];
    logic              bt_last [MAXB];
    int nb = 0;
    int viol_r6 = 0;
    int viol_r7 = 0;
    logic              pv = 0, pr = 0, pl = 0;
    logic [WORD_W-1:0] pd = '0;

    always #4 clk = ~clk;

    arr_burst_ser #(.WORD_W(WORD_W), .ELEM_W(ELEM_W), .CNT_W(CNT_W)) i_arr_burst_ser (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .count_i      (count_i),
        .elem_valid_i (elem_valid_i),
        .elem_ready_o (elem_ready_o),
        .elem_data_i  (elem_data_i),
        .m_tvalid     (m_tvalid),
        .m_tready     (m_tready),
        .m_tdata      (m_tdata),
        .m_tlast      (m_tlast),
        .busy_o       (busy_o),
        .err_o        (err_o)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
    end
    assign m_tready = bp_en ? ((cyc % 3) != 0) : 1'b1;

    always @(negedge clk) begin
        if (!rst) begin
            if (pv && !pr && !(m_tvalid && m_tdata == pd && m_tlast == pl)) viol_r6++;
            if (m_tvalid && elem_ready_o) viol_r7++;
            if (busy_o && !m_tvalid && !elem_ready_o) viol_r7++;
            if (m_tvalid && m_tready) begin
                if (nb < MAXB) begin
                    bt_data[nb] = m_tdata;
                    bt_last[nb] = m_tlast;
                end
                nb++;
            end
            pv = m_tvalid; pr = m_tready; pd = m_tdata; pl = m_tlast;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [ELEM_W-1:0] elem_val(input int p, input int e);
        logic [ELEM_W-1:0] v;
        v = {16'(16'hFFFF - e), 32'(32'hA500_0000 + p * 256 + e), 32'(32'h1234_0000 + e * 3)};
        return v;
    endfunction

    task automatic run_packet(input int p, input int n, input bit bp, input bit poke);
        logic [SR_W-1:0] ext;
        logic [WORD_W-1:0] expw;
        int k;
        int guard;
        bit ok_data;
        bit ok_last;
        bp_en = bp;
        nb = 0; viol_r6 = 0; viol_r7 = 0;
        @(posedge clk); #1;
        start_i = 1'b1; count_i = CNT_W'(n);
        @(posedge clk); #1;
        start_i = 1'b0;
        check(busy_o == 1'b1, "R9", "busy after start", busy_o, 1);
        for (int e = 0; e < n; e++) begin
            elem_valid_i = 1'b1;
            elem_data_i = elem_val(p, e);
            guard = 0;
            do begin
                @(negedge clk);
                guard++;
            end while (!elem_ready_o && guard < 1000);
            @(posedge clk); #1;
            elem_valid_i = 1'b0;
            if (poke && e == 0) begin
                start_i = 1'b1; count_i = CNT_W'(n + 5);
                @(posedge clk); #1;
                start_i = 1'b0;
            end
        end
        guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (busy_o && guard < 1000);
        repeat (4) @(negedge clk);
        check(nb == n * WPE, (n == 1) ? "R5" : "R1", "beat count", nb, n * WPE);
        ok_data = 1; ok_last = 1;
        for (int e = 0; e < n && ok_data; e++) begin
            ext = SR_W'(elem_val(p, e));
            for (int w = 0; w < WPE; w++) begin
                k = e * WPE + w;
                expw = ext[w*WORD_W +: WORD_W];
                if (k < MAXB && k < nb && bt_data[k] !== expw) begin
                    check(0, (w == WPE - 1) ? "R4" : "R3", "word", bt_data[k], expw);
                    ok_data = 0;
                    break;
                end
                if (k < MAXB && k < nb && bt_last[k] !== (k == n * WPE - 1)) ok_last = 0;
            end
        end
        if (ok_data) check(1, "R3", "word order", 0, 0);
        check(ok_last, (n == 1) ? "R5" : "R2", "tlast placement", ok_last, 1);
        check(viol_r6 == 0, "R6", "hold under backpressure", viol_r6, 0);
        check(viol_r7 == 0, "R7", "element ready gating", viol_r7, 0);
        check(busy_o == 1'b0, poke ? "R9" : "R2", "busy after packet", busy_o, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(busy_o == 0, "R10", "busy in reset", busy_o, 0);
        check(m_tvalid == 0, "R10", "tvalid in reset", m_tvalid, 0);
        check(elem_ready_o == 0, "R10", "ready in reset", elem_ready_o, 0);
        check(err_o == 0, "R10", "err in reset", err_o, 0);
    endtask

    task automatic t_zero_count();
        int nb0;
        nb0 = nb;
        @(posedge clk); #1;
        start_i = 1'b1; count_i = '0;
        @(posedge clk); #1;
        start_i = 1'b0;
        @(negedge clk);
        check(err_o == 1, "R8", "err pulse", err_o, 1);
        check(busy_o == 0, "R8", "busy on zero count", busy_o, 0);
        @(negedge clk);
        check(err_o == 0, "R8", "err one cycle", err_o, 0);
        repeat (4) @(negedge clk);
        check(nb == nb0, "R8", "no beats", nb, nb0);
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        #1 rst = 1'b0;
        run_packet(1, 1, 0, 0);
        run_packet(2, 4, 0, 0);
        run_packet(3, 3, 1, 1);
        t_zero_count();
        run_packet(4, 6, 1, 0);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule